// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block turns single-word host requests into the command stream for a 16-bit synchronous DRAM with four banks. Each bank has 8192 rows of 512 columns. After reset it holds clock enable low for a power-up delay. It then raises clock enable, precharges every bank, issues a set of auto-refreshes and programs the mode register for single-word bursts at the chosen CAS latency. Only after that does it lower its busy flag.

Every access uses a closed-page scheme. The controller activates the row, issues a read or write with auto-precharge, then waits out the recovery time before it returns to idle. A free-running interval counter flags a pending refresh. That refresh is issued as soon as the controller is idle, ahead of any waiting host request. The byte enables become the two data masks. A write mask goes out in the same cycle as the write. A read mask goes out two cycles before the read data arrives. Read data is captured from the data input bus CAS-latency cycles after the device samples the read command.

Top module: `sdram_ctrl`

## Requirements
- R1: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: NOP 0111, ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, MODE LOAD 0000. Clock enable is low from reset through the power-up delay. It is high in the cycle before every non-NOP command.
- R2: The init sequence starts no earlier than PWRUP_CYCLES cycles after reset release. It runs in this order: a PRECHARGE with address bit 10 high, then INIT_REFS REFRESH commands, then a MODE LOAD with address bits 6:4 holding CL and every other address bit zero (burst of one, sequential). Busy stays high until the sequence is complete.
- R3: The host address splits as bank = addr[23:22], row = addr[21:9], column = addr[8:0]. ACTIVATE carries the bank and row. READ and WRITE carry the same bank and the column on address bits 8:0, with bit 10 high to request auto-precharge.
- R4: READ or WRITE follows its ACTIVATE exactly TRCD cycles later, to the same bank.
- R5: In the WRITE cycle, dq_oe is high, dq_out holds the write data and the masks equal the inverted byte enables (mask bit 1 covers bits 15:8, bit 0 covers 7:0). dq_oe is never high in any other cycle.
- R6: For a read, the masks equal the inverted byte enables in the cycle CL-2 cycles after the READ command. A masked byte is therefore not driven by the memory.
- R7: rd_valid pulses for one cycle, TRCD+CL+2 cycles after the cycle in which a request was accepted. rd_data then holds the word that was on the data input bus CL cycles after the READ.
- R8: A request is accepted only in a cycle with req_valid high and busy low. ACTIVATE follows in the next cycle. A request presented while busy is high has no effect. Busy stays high until CL+TRP cycles after a READ, or TWR+TRP cycles after a WRITE, have passed.
- R9: A refresh becomes pending every REF_INTERVAL cycles. When idle, a pending refresh is issued before any host request. No command follows a REFRESH within TRFC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Linear word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 = upper byte |
| busy | output | 1 | Request will not be accepted this cycle |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Captured read word |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 13 | Multiplexed row/column address |
| sd_dqm | output | 2 | Byte masks |
| sd_dq_out | output | 16 | Data toward memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Data from memory |

## Verification
The hardest case to reach is a refresh coming due while the host is streaming back-to-back requests. The refresh must then win the idle slot and still land inside its interval bound. A long run of alternating writes and reads is driven with no idle gaps, so that refresh ticks fall at many phases of an access. The behavioural memory checks the spacing of every REFRESH and every command that follows one. Read masking is checked the same way, through a memory model that zeroes masked bytes using the mask seen two cycles earlier. Partial-byte reads therefore return wrong data if the mask is one cycle early or late. A request raised while busy is high carries a junk write. The bench later reads that address back to prove the write had no effect.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_CKE,
    ST_PREA,
    ST_IREF,
    ST_MRS,
    ST_IDLE,
    ST_AREF,
    ST_ACT,
    ST_RW,
    ST_WAIT
  } sdc_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_ACT = 4'b0011;
  localparam logic [3:0] CMD_RD  = 4'b0101;
  localparam logic [3:0] CMD_WR  = 4'b0100;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

endpackage

// File: rtl/sdc_timer.sv
module sdc_timer #(
  parameter int TW      = 16,
  parameter int RST_VAL = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= TW'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign expire = (cnt_q <= TW'(1));

  // a load of two or more keeps the wait open for the following cycle
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val > TW'(1)) |=> !expire); // R4

endmodule

// File: rtl/sdc_refresh.sv
module sdc_refresh #(
  parameter int INTERVAL = 975
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_done,
  output logic pending
);

  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick;
  logic          pend_q, pend_d;

  assign tick = (cnt_q == CW'(INTERVAL - 1));

  always_comb begin
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    pend_d = tick | (pend_q & ~ref_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;

  AST_REF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ref_done) |=> pending); // R9

endmodule

// File: rtl/sdc_rd_path.sv
module sdc_rd_path #(
  parameter int CL  = 3,
  parameter int DW  = 16,
  parameter int BEW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_issue,
  input  logic [BEW-1:0] rd_mask,
  input  logic [DW-1:0]  dq_in,
  output logic [BEW-1:0] rd_dqm,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data
);

  logic [CL-1:0] vld_q, vld_d;
  logic          rv_q;
  logic [DW-1:0] data_q;
  logic          cap_en;

  always_comb vld_d = {vld_q[CL-2:0], rd_issue};
  assign cap_en = vld_q[CL-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rv_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      rv_q  <= cap_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (cap_en) data_q <= dq_in;
  end

  assign rd_valid = rv_q;
  assign rd_data  = data_q;

  // read masks lead the data by two cycles
  generate
    if (CL == 2) begin : g_mask_now
      assign rd_dqm = rd_issue ? rd_mask : '0;
    end else begin : g_mask_dly
      logic [BEW-1:0] m_q [CL-2];
      logic [BEW-1:0] m_d [CL-2];
      always_comb begin
        m_d[0] = rd_issue ? rd_mask : '0;
        for (int i = 1; i < CL - 2; i++) m_d[i] = m_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < CL - 2; i++) m_q[i] <= '0;
        end else begin
          for (int i = 0; i < CL - 2; i++) m_q[i] <= m_d[i];
        end
      end
      assign rd_dqm = m_q[CL-3];
    end
  endgenerate

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R7

endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
  import sdc_pkg::*;
#(
  parameter int CL           = 3,
  parameter int TRCD         = 3,
  parameter int TRP          = 3,
  parameter int TWR          = 2,
  parameter int TRFC         = 9,
  parameter int TMRD         = 2,
  parameter int INIT_REFS    = 2,
  parameter int PWRUP_CYCLES = 25000,
  parameter int REF_INTERVAL = 975,
  parameter int BA_W         = 2,
  parameter int ROW_W        = 13,
  parameter int COL_W        = 9,
  parameter int DW           = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_we,
  input  logic [BA_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DW-1:0]                 req_wdata,
  input  logic [DW/8-1:0]               req_be,
  output logic                          busy,
  output logic                          rd_valid,
  output logic [DW-1:0]                 rd_data,
  output logic                          sd_cke,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BA_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]              sd_addr,
  output logic [DW/8-1:0]               sd_dqm,
  output logic [DW-1:0]                 sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DW-1:0]                 sd_dq_in
);

  localparam int AW  = BA_W + ROW_W + COL_W;
  localparam int BEW = DW / 8;
  localparam int TW  = $clog2(PWRUP_CYCLES + TRFC + TRCD + TRP + CL + TWR + TMRD + 2);
  localparam int IW  = $clog2(INIT_REFS + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s_n  <= rst_meta;
    end
  end

  sdc_state_e      state_q, state_d, ret_q, ret_d;
  logic [IW-1:0]   iref_q, iref_d;
  logic            q_we;
  logic [AW-1:0]   q_addr;
  logic [DW-1:0]   q_wdata;
  logic [BEW-1:0]  q_be;
  logic            accept;
  logic            tmr_load, tmr_exp;
  logic [TW-1:0]   tmr_val;
  logic            ref_pend, ref_done;
  logic [3:0]      cmd;
  logic [ROW_W-1:0] addr_o;
  logic [BA_W-1:0] ba_o;
  logic            rd_issue;
  logic [BEW-1:0]  rd_dqm;

  sdc_timer #(.TW(TW), .RST_VAL(PWRUP_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_s_n), .load(tmr_load), .load_val(tmr_val), .expire(tmr_exp)
  );

  sdc_refresh #(.INTERVAL(REF_INTERVAL)) u_refresh (
    .clk(clk), .rst_n(rst_s_n), .ref_done(ref_done), .pending(ref_pend)
  );

  sdc_rd_path #(.CL(CL), .DW(DW), .BEW(BEW)) u_rd_path (
    .clk(clk), .rst_n(rst_s_n), .rd_issue(rd_issue), .rd_mask(~q_be),
    .dq_in(sd_dq_in), .rd_dqm(rd_dqm), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // next-state and command decode
  always_comb begin
    state_d  = state_q;
    ret_d    = ret_q;
    iref_d   = iref_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cmd      = CMD_NOP;
    addr_o   = '0;
    ba_o     = '0;
    accept   = 1'b0;
    ref_done = 1'b0;
    case (state_q)
      ST_PWRUP: if (tmr_exp) state_d = ST_CKE;
      ST_CKE:   state_d = ST_PREA;
      ST_PREA: begin
        cmd        = CMD_PRE;
        addr_o[10] = 1'b1;
        tmr_load   = 1'b1;
        tmr_val    = TW'(TRP - 1);
        ret_d      = ST_IREF;
        state_d    = ST_WAIT;
      end
      ST_IREF: begin
        cmd      = CMD_REF;
        iref_d   = iref_q + 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TW'(TRFC - 1);
        ret_d    = (iref_q == IW'(INIT_REFS - 1)) ? ST_MRS : ST_IREF;
        state_d  = ST_WAIT;
      end
      ST_MRS: begin
        cmd         = CMD_MRS;
        addr_o[6:4] = 3'(CL);
        tmr_load    = 1'b1;
        tmr_val     = TW'(TMRD - 1);
        ret_d       = ST_IDLE;
        state_d     = ST_WAIT;
      end
      ST_IDLE: begin
        if (ref_pend) begin
          state_d = ST_AREF;
        end else if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_ACT;
        end
      end
      ST_AREF: begin
        cmd      = CMD_REF;
        ref_done = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TW'(TRFC - 1);
        ret_d    = ST_IDLE;
        state_d  = ST_WAIT;
      end
      ST_ACT: begin
        cmd      = CMD_ACT;
        ba_o     = q_addr[AW-1 -: BA_W];
        addr_o   = q_addr[COL_W +: ROW_W];
        tmr_load = 1'b1;
        tmr_val  = TW'(TRCD - 1);
        ret_d    = ST_RW;
        state_d  = ST_WAIT;
      end
      ST_RW: begin
        cmd                = q_we ? CMD_WR : CMD_RD;
        ba_o               = q_addr[AW-1 -: BA_W];
        addr_o[COL_W-1:0]  = q_addr[COL_W-1:0];
        addr_o[10]         = 1'b1;
        tmr_load           = 1'b1;
        tmr_val            = q_we ? TW'(TWR + TRP) : TW'(CL + TRP);
        ret_d              = ST_IDLE;
        state_d            = ST_WAIT;
      end
      ST_WAIT: if (tmr_exp) state_d = ret_q;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_PWRUP;
      ret_q   <= ST_PWRUP;
      iref_q  <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      iref_q  <= iref_d;
    end
  end

  // request holding registers, loaded on acceptance only
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      q_we    <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
      q_be    <= '0;
    end else if (accept) begin
      q_we    <= req_we;
      q_addr  <= req_addr;
      q_wdata <= req_wdata;
      q_be    <= req_be;
    end
  end

  assign rd_issue = (state_q == ST_RW) && !q_we;
  assign busy     = !((state_q == ST_IDLE) && !ref_pend);

  assign sd_cke                               = (state_q != ST_PWRUP);
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_ba                                = ba_o;
  assign sd_addr                              = addr_o;
  assign sd_dq_out                            = q_wdata;
  assign sd_dq_oe                             = (state_q == ST_RW) && q_we;
  assign sd_dqm                               = sd_dq_oe ? ~q_be : rd_dqm;

  AST_CKE_LEAD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd != CMD_NOP) |-> $past(sd_cke)); // R1
  AST_ACT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd == CMD_ACT) |-> $past(req_valid && !busy)); // R8
  AST_REF_FIRST: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_IDLE && ref_pend) |=> (cmd == CMD_REF)); // R9
  AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_s_n)
    sd_dq_oe |-> (cmd == CMD_WR && sd_addr[10])); // R5

endmodule

// File: tb/tb_sdram_ctrl.sv
`timescale 1ns/1ps
module tb_sdram_ctrl;

  localparam int CL = 3, TRCD = 3, TRP = 3, TWR = 2, TRFC = 9, TMRD = 2;
  localparam int INIT_REFS = 2, PWRUP = 50, REF_INT = 300;
  localparam int SLACK = TRCD + CL + TRP + TWR + 4;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_we;
  logic [23:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic busy, rd_valid;
  logic [15:0] rd_data;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [12:0] sd_addr;
  logic [1:0]  sd_dqm;
  logic [15:0] sd_dq_out;
  logic        sd_dq_oe;
  logic [15:0] sd_dq_in;

  sdram_ctrl #(.CL(CL), .TRCD(TRCD), .TRP(TRP), .TWR(TWR), .TRFC(TRFC), .TMRD(TMRD),
               .INIT_REFS(INIT_REFS), .PWRUP_CYCLES(PWRUP), .REF_INTERVAL(REF_INT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in)
  );

  always #4 clk = ~clk;

  typedef struct { logic we; logic [23:0] addr; logic [15:0] wdata; logic [1:0] be; int acc; } req_t;
  typedef struct { int due; logic [15:0] data; } due_t;
  typedef struct { int due; logic [1:0] m; } mchk_t;

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0, mon_en = 0;
  int rel_cyc = 0;

  req_t  accq[$];
  due_t  rvq[$];
  due_t  drvq[$];
  mchk_t mq[$];
  logic [15:0] ref_mem [int unsigned];
  logic [15:0] dev_mem [int unsigned];

  // monitor state
  logic prev_cke = 1'b0;
  logic [1:0] h1 = 2'b00, h2 = 2'b00;
  int init_idx = 0;
  bit init_done = 0;
  bit have_ref = 0;
  int last_ref = 0, ref_count = 0;
  int last_cmd = -1000, min_gap = 0;
  string gap_tag = "R8";
  bit bank_open [4];
  int act_at [4];
  logic [12:0] orow [4];
  int busy_from = 0, busy_to = -1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] bmask(input logic [1:0] keep);
    return {{8{keep[1]}}, {8{keep[0]}}};
  endfunction

  // behavioural memory and per-cycle comparison
  always @(negedge clk) begin
    if (mon_en) begin
      logic [3:0] cmd;
      bit is_cmd;
      int unsigned key;
      logic [15:0] old;
      cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      is_cmd = !sd_cs_n && (cmd[2:0] != 3'b111);
      if (is_cmd) begin
        chk("R1 clock enable high before command", {31'd0, prev_cke}, 32'd1);
        if (cyc - last_cmd < min_gap) chk({gap_tag, " command spacing"}, cyc - last_cmd, min_gap);
        last_cmd = cyc;
        min_gap = 0;
      end
      if (is_cmd) begin
        case (cmd)
          4'b0010: begin
            if (init_idx == 0) begin
              chk("R2 precharge-all bit 10", {31'd0, sd_addr[10]}, 32'd1);
              chk("R2 power-up delay respected", {31'd0, (cyc - rel_cyc) >= PWRUP}, 32'd1);
              init_idx++;
            end else chk("R2 unexpected precharge", 32'd1, 32'd0);
          end
          4'b0001: begin
            chk("R9 refresh with all banks closed",
                {31'd0, bank_open[0] | bank_open[1] | bank_open[2] | bank_open[3]}, 32'd0);
            if (!init_done) begin
              chk("R2 refresh order", {31'd0, init_idx >= 1 && init_idx <= INIT_REFS}, 32'd1);
              init_idx++;
            end else begin
              if (have_ref)
                chk("R9 refresh interval bound", {31'd0, (cyc - last_ref) <= REF_INT + SLACK}, 32'd1);
              have_ref = 1;
              last_ref = cyc;
              ref_count++;
            end
            min_gap = TRFC; gap_tag = "R9";
          end
          4'b0000: begin
            chk("R2 mode load position", init_idx, INIT_REFS + 1);
            chk("R2 mode word", {19'd0, sd_addr}, 32'(CL << 4));
            init_idx++;
            init_done = 1;
          end
          4'b0011: begin
            chk("R8 activate has an accepted request", {31'd0, accq.size() != 0}, 32'd1);
            chk("R4 activate to closed bank", {31'd0, bank_open[sd_ba]}, 32'd0);
            if (accq.size() != 0) begin
              chk("R3 activate bank", {30'd0, sd_ba}, {30'd0, accq[0].addr[23:22]});
              chk("R3 activate row", {19'd0, sd_addr}, {19'd0, accq[0].addr[21:9]});
              chk("R8 activate one cycle after accept", cyc, accq[0].acc + 1);
            end
            bank_open[sd_ba] = 1;
            act_at[sd_ba] = cyc;
            orow[sd_ba] = sd_addr;
          end
          4'b0101, 4'b0100: begin
            chk("R3 auto-precharge bit 10", {31'd0, sd_addr[10]}, 32'd1);
            chk("R4 column command to open bank", {31'd0, bank_open[sd_ba]}, 32'd1);
            chk("R4 activate to column spacing", cyc - act_at[sd_ba], TRCD);
            key = {sd_ba, orow[sd_ba], sd_addr[8:0]};
            if (accq.size() != 0) begin
              chk("R3 column bank", {30'd0, sd_ba}, {30'd0, accq[0].addr[23:22]});
              chk("R3 column address", {23'd0, sd_addr[8:0]}, {23'd0, accq[0].addr[8:0]});
              if (cmd == 4'b0100) begin
                chk("R5 write output enable", {31'd0, sd_dq_oe}, 32'd1);
                chk("R5 write data", {16'd0, sd_dq_out}, {16'd0, accq[0].wdata});
                chk("R5 write mask", {30'd0, sd_dqm}, {30'd0, ~accq[0].be});
              end else begin
                mq.push_back('{due: cyc + CL - 2, m: ~accq[0].be});
              end
              void'(accq.pop_front());
            end
            if (cmd == 4'b0100) begin
              old = dev_mem.exists(key) ? dev_mem[key] : 16'h0000;
              dev_mem[key] = (old & bmask(sd_dqm)) | (sd_dq_out & ~bmask(sd_dqm));
              min_gap = TWR + TRP + 1;
            end else begin
              drvq.push_back('{due: cyc + CL, data: dev_mem.exists(key) ? dev_mem[key] : 16'h0000});
              min_gap = CL + TRP + 1;
            end
            gap_tag = "R8";
            bank_open[sd_ba] = 0;
          end
          default: chk("R1 unknown command", {28'd0, cmd}, 32'h7);
        endcase
      end
      if (sd_dq_oe && !(is_cmd && cmd == 4'b0100)) chk("R5 output enable outside write", 32'd1, 32'd0);
      if (mq.size() != 0 && mq[0].due == cyc) begin
        chk("R6 read mask timing", {30'd0, sd_dqm}, {30'd0, mq[0].m});
        void'(mq.pop_front());
      end
      if (drvq.size() != 0 && drvq[0].due == cyc) begin
        sd_dq_in = drvq[0].data & ~bmask(h2);
        void'(drvq.pop_front());
      end else sd_dq_in = 16'hDEAD;
      if (rvq.size() != 0 && rvq[0].due == cyc) begin
        chk("R7 read valid timing", {31'd0, rd_valid}, 32'd1);
        chk("R7 read data", {16'd0, rd_data}, {16'd0, rvq[0].data});
        void'(rvq.pop_front());
      end else if (rd_valid) chk("R7 unexpected read valid", 32'd1, 32'd0);
      if (cyc >= busy_from && cyc <= busy_to && !busy) chk("R8 busy during access", 32'd0, 32'd1);
      prev_cke = sd_cke;
      h2 = h1;
      h1 = sd_dqm;
    end
  end

  // host request: called at a falling edge
  task automatic host_req(input logic we, input logic [23:0] addr, input logic [15:0] d,
                          input logic [1:0] be);
    logic [15:0] old;
    while (busy) @(negedge clk);
    if (!init_done) chk("R2 request accepted before init", 32'd1, 32'd0);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = d; req_be = be;
    accq.push_back('{we: we, addr: addr, wdata: d, be: be, acc: cyc});
    old = ref_mem.exists(addr) ? ref_mem[addr] : 16'h0000;
    if (we) ref_mem[addr] = (old & ~bmask(be)) | (d & bmask(be));
    else rvq.push_back('{due: cyc + TRCD + CL + 2, data: old & bmask(be)});
    busy_from = cyc + 1;
    busy_to = cyc + 1 + TRCD + (we ? TWR : CL) + TRP;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    sd_dq_in = 16'hDEAD;
    repeat (3) @(negedge clk);
    chk("R1 clock enable low in reset", {31'd0, sd_cke}, 32'd0);
    chk("R1 NOP in reset", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'h7);
    chk("R2 busy in reset", {31'd0, busy}, 32'd1);
    chk("R7 no read valid in reset", {31'd0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    rel_cyc = cyc;
    mon_en = 1;
    repeat (PWRUP / 2) @(negedge clk);
    chk("R1 clock enable low during power-up", {31'd0, sd_cke}, 32'd0);
    chk("R2 busy during power-up", {31'd0, busy}, 32'd1);
    while (busy) @(negedge clk);
    chk("R2 init sequence complete", init_idx, INIT_REFS + 2);

    // corner addresses, full words
    host_req(1, 24'h000000, 16'h1234, 2'b11);
    host_req(1, 24'hFFFFFF, 16'hBEEF, 2'b11);
    host_req(1, 24'h4A5A5A, 16'hC0DE, 2'b11);
    host_req(0, 24'h000000, 16'h0000, 2'b11);
    host_req(0, 24'hFFFFFF, 16'h0000, 2'b11);
    host_req(0, 24'h4A5A5A, 16'h0000, 2'b11);
    // partial-byte writes and reads
    host_req(1, 24'h4A5A5A, 16'hAA55, 2'b01);
    host_req(1, 24'hFFFFFF, 16'h7711, 2'b10);
    host_req(0, 24'h4A5A5A, 16'h0000, 2'b11);
    host_req(0, 24'hFFFFFF, 16'h0000, 2'b10);
    host_req(0, 24'h000000, 16'h0000, 2'b01);
    host_req(0, 24'h4A5A5A, 16'h0000, 2'b00);
    // request while busy must be ignored
    host_req(1, 24'h812345, 16'h5151, 2'b11);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 24'h812345; req_wdata = 16'hFFFF; req_be = 2'b11;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    host_req(0, 24'h812345, 16'h0000, 2'b11);
    // idle long enough for several refreshes
    repeat (3 * REF_INT) @(negedge clk);
    // back-to-back stream across many refresh phases
    for (int i = 0; i < 400; i++) begin
      logic [23:0] a;
      a = 24'((i * 32'h9E377) ^ (i << 13));
      host_req(1, a, 16'((i * 16'h3B1) ^ 16'h5A5A), 2'(i % 3 + 1));
      host_req(0, a, 16'h0000, 2'(3 - i % 4));
    end
    repeat (40) @(negedge clk);
    chk("R7 all reads returned", rvq.size(), 0);
    chk("R8 all requests issued", accq.size(), 0);
    chk("R9 refreshes issued", {31'd0, ref_count >= 8}, 32'd1);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired R8 actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule